// File: doc/BRIEF.md
# Level-Masked Interrupt Acceptance Controller

This block decides when the processor takes a peripheral interrupt. Every request line carries a 3-bit priority level and a kind. The level is compared with a processor-status level mask, and acceptance also needs a global enable flag. Among the requests that pass, one winner is chosen. A plain interrupt winner makes the block ask the core to save its context. The mask then takes the winner's level. Once the core reports the save as done, the block presents the interrupt number and its vector address for the branch.

A request can instead name one of two automatic transfer services: an I/O transfer service driven by descriptors, or a DMA service. For such a request the block starts the external transfer engine and does not interrupt the core. While the engine runs, every other request is held pending. When the engine reports completion, the block raises a plain interrupt for the same number at the same level. A return input restores the mask and enable flag that were saved when an interrupt was accepted, so interrupts can nest to a parameterised depth.

Top module: `irq_accept`

## Requirements
- R1: After reset the mask reads 7, the enable flag reads 0, and `ctx_save_req`, `branch_valid`, `svc_start` and `svc_busy` are all low.
- R2: A request is accepted only if the enable flag is 1 and its level is numerically less than the mask. Level 7 is therefore never accepted. While the flag is 0, nothing is accepted.
- R3: Among the acceptable requests, the lowest level wins. When levels are equal, the lowest interrupt number wins.
- R4: One cycle after a plain interrupt is accepted, `ctx_save_req` rises and the mask holds the accepted level. `ctx_save_req` stays high until the cycle in which `ctx_save_done` is sampled high.
- R5: In the cycle after `ctx_save_done` is sampled, `branch_valid` is high for exactly one cycle. In that cycle `branch_num` is the accepted number n and `branch_vec` is 0xFFFFFC − 4·n (24 bits).
- R6: While idle, a `reti` pulse restores the mask and enable flag saved at the matching acceptance. A `ps_we` pulse loads them from `ps_ilm_in` and `ps_ien_in`. In a cycle with either pulse nothing is accepted; requests are evaluated again on the next clock.
- R7: The kind field of each request line is 2 bits: 0 for a plain interrupt, 1 for the I/O transfer service, 2 for the DMA service, and 3 treated as plain. An accepted service request gives a one-cycle `svc_start` carrying `svc_kind` and `svc_num`. `svc_busy` stays high until `svc_done` is sampled. No context save is requested and the mask does not change.
- R8: While `svc_busy` is high, no request of any kind is accepted and no further service is started.
- R9: After `svc_done`, the block raises a plain interrupt for the same number at its original level. This interrupt goes through the R2 and R3 rules like any other request, even after the request line has dropped.
- R10: A handler that is running can be interrupted by a request with a lower level value than its own. `reti` then restores the mask values in reverse order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NUM_IRQ | Request line per interrupt number |
| req_level | input | NUM_IRQ*3 | Level of number i in bits [3i+2:3i] |
| req_kind | input | NUM_IRQ*2 | Kind of number i in bits [2i+1:2i] |
| ps_we | input | 1 | Load mask and enable flag |
| ps_ilm_in | input | 3 | Mask value to load |
| ps_ien_in | input | 1 | Enable flag value to load |
| reti | input | 1 | Return from interrupt |
| ctx_save_done | input | 1 | Core finished saving its context |
| svc_done | input | 1 | Transfer engine finished |
| ilm | output | 3 | Current level mask |
| ien | output | 1 | Current global enable flag |
| ctx_save_req | output | 1 | Request to the core to save its context |
| branch_valid | output | 1 | Branch to the vector now |
| branch_num | output | NUM_W | Accepted interrupt number |
| branch_vec | output | 24 | Vector address of the accepted number |
| svc_start | output | 1 | Start pulse for the transfer engine |
| svc_kind | output | 2 | Service kind being started |
| svc_num | output | NUM_W | Number whose service is running |
| svc_busy | output | 1 | A transfer service is in progress |

## Verification
A bad mask register or a bad saved-context entry shows up at the `ilm` and `ien` outputs. The mask is visible one cycle after an acceptance and the saved entry one cycle after a `reti`, so every sweep point checks both. A wrong arbitration choice shows up as a wrong `branch_num` or `branch_vec` two cycles after acceptance. A missed acceptance shows up one cycle early, as `ctx_save_req` staying low. A leak of the service lockout shows up as `ctx_save_req` or a second `svc_start` while `svc_busy` is high. A lost completion shows up as no context request in the second cycle after `svc_done`.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W = 3;
    localparam int VEC_W = 24;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAVE   = 2'd1,
        ST_BRANCH = 2'd2,
        ST_SVC    = 2'd3
    } acc_state_e;

    localparam logic [1:0] KIND_PLAIN = 2'd0;
    localparam logic [1:0] KIND_IOSVC = 2'd1;
    localparam logic [1:0] KIND_DMA   = 2'd2;

    function automatic logic [VEC_W-1:0] vec_of(input logic [7:0] n);
        return 24'hFFFFFC - {14'd0, n, 2'b00};
    endfunction

    function automatic logic is_service(input logic [1:0] k);
        return (k == KIND_IOSVC) || (k == KIND_DMA);
    endfunction
endpackage

// File: rtl/irq_arb.sv
module irq_arb #(
    parameter int NUM_IRQ = 8,
    parameter int NUM_W   = 3
) (
    input  logic [NUM_IRQ-1:0]   cand_valid,
    input  logic [NUM_IRQ*3-1:0] cand_level,
    input  logic [NUM_IRQ*2-1:0] cand_kind,
    input  logic [2:0]           mask,
    output logic                 hit,
    output logic [NUM_W-1:0]     win_num,
    output logic [2:0]           win_lvl,
    output logic [1:0]           win_kind
);
    logic [NUM_IRQ-1:0] pass;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_pass
        assign pass[g] = cand_valid[g] && (cand_level[g*3 +: 3] < mask);
    end

    always_comb begin
        hit      = 1'b0;
        win_num  = '0;
        win_lvl  = 3'd7;
        win_kind = 2'd0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pass[i] && (!hit || cand_level[i*3 +: 3] < win_lvl)) begin
                hit      = 1'b1;
                win_num  = NUM_W'(i);
                win_lvl  = cand_level[i*3 +: 3];
                win_kind = cand_kind[i*2 +: 2];
            end
        end
    end
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;
    logic [CNT_W-1:0]        cnt_d, cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign rdata = empty ? '0 : mem_q[cnt_q - 1'b1];

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        if (push && !full) begin
            mem_d[cnt_q] = wdata;
            cnt_d        = cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
            cnt_q <= '0;
        end else begin
            mem_q <= mem_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import irq_pkg::*;
#(
    parameter int NUM_IRQ   = 8,
    parameter int NEST_MAX  = 8,
    parameter int NUM_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   req_valid,
    input  logic [NUM_IRQ*3-1:0] req_level,
    input  logic [NUM_IRQ*2-1:0] req_kind,
    input  logic                 ps_we,
    input  logic [2:0]           ps_ilm_in,
    input  logic                 ps_ien_in,
    input  logic                 reti,
    input  logic                 ctx_save_done,
    input  logic                 svc_done,
    output logic [2:0]           ilm,
    output logic                 ien,
    output logic                 ctx_save_req,
    output logic                 branch_valid,
    output logic [NUM_W-1:0]     branch_num,
    output logic [VEC_W-1:0]     branch_vec,
    output logic                 svc_start,
    output logic [1:0]           svc_kind,
    output logic [NUM_W-1:0]     svc_num,
    output logic                 svc_busy
);
    typedef struct packed {
        acc_state_e                st;
        logic [2:0]                ilm;
        logic                      ien;
        logic [NUM_W-1:0]          cur_num;
        logic [2:0]                cur_lvl;
        logic                      svc_go;
        logic [1:0]                svc_kind;
        logic [NUM_IRQ-1:0]        done_pend;
        logic [NUM_IRQ-1:0][2:0]   done_lvl;
    } acc_regs_t;

    acc_regs_t r_d, r_q;

    logic [NUM_IRQ-1:0]   cand_valid;
    logic [NUM_IRQ*3-1:0] cand_level;
    logic [NUM_IRQ*2-1:0] cand_kind;
    logic                 hit;
    logic [NUM_W-1:0]     win_num;
    logic [2:0]           win_lvl;
    logic [1:0]           win_kind;
    logic                 stk_push, stk_pop, stk_empty, stk_full;
    logic [3:0]           stk_rdata;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_cand
        assign cand_valid[g]       = req_valid[g] | r_q.done_pend[g];
        assign cand_level[g*3 +: 3] = r_q.done_pend[g] ? r_q.done_lvl[g] : req_level[g*3 +: 3];
        assign cand_kind[g*2 +: 2]  = r_q.done_pend[g] ? KIND_PLAIN : req_kind[g*2 +: 2];
    end

    irq_arb #(.NUM_IRQ(NUM_IRQ), .NUM_W(NUM_W)) u_arb (
        .cand_valid (cand_valid),
        .cand_level (cand_level),
        .cand_kind  (cand_kind),
        .mask       (r_q.ilm),
        .hit        (hit),
        .win_num    (win_num),
        .win_lvl    (win_lvl),
        .win_kind   (win_kind)
    );

    irq_ctx_stack #(.DEPTH(NEST_MAX), .W(4)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .wdata ({r_q.ien, r_q.ilm}),
        .rdata (stk_rdata),
        .empty (stk_empty),
        .full  (stk_full)
    );

    always_comb begin
        r_d      = r_q;
        r_d.svc_go = 1'b0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (reti) begin
                    if (!stk_empty) begin
                        stk_pop = 1'b1;
                        r_d.ien = stk_rdata[3];
                        r_d.ilm = stk_rdata[2:0];
                    end
                end else if (ps_we) begin
                    r_d.ilm = ps_ilm_in;
                    r_d.ien = ps_ien_in;
                end else if (r_q.ien && hit && !stk_full) begin
                    r_d.cur_num            = win_num;
                    r_d.cur_lvl            = win_lvl;
                    r_d.done_pend[win_num] = 1'b0;
                    if (is_service(win_kind)) begin
                        r_d.st       = ST_SVC;
                        r_d.svc_go   = 1'b1;
                        r_d.svc_kind = win_kind;
                    end else begin
                        r_d.st   = ST_SAVE;
                        stk_push = 1'b1;
                        r_d.ilm  = win_lvl;
                    end
                end
            end
            ST_SAVE: begin
                if (ctx_save_done) r_d.st = ST_BRANCH;
            end
            ST_BRANCH: begin
                r_d.st = ST_IDLE;
            end
            ST_SVC: begin
                if (svc_done) begin
                    r_d.st                     = ST_IDLE;
                    r_d.done_pend[r_q.cur_num] = 1'b1;
                    r_d.done_lvl[r_q.cur_num]  = r_q.cur_lvl;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.ilm <= 3'd7;
        end else begin
            r_q <= r_d;
        end
    end

    assign ilm          = r_q.ilm;
    assign ien          = r_q.ien;
    assign ctx_save_req = (r_q.st == ST_SAVE);
    assign branch_valid = (r_q.st == ST_BRANCH);
    assign branch_num   = r_q.cur_num;
    assign branch_vec   = vec_of(8'(r_q.cur_num));
    assign svc_start    = r_q.svc_go;
    assign svc_kind     = r_q.svc_kind;
    assign svc_num      = r_q.cur_num;
    assign svc_busy     = (r_q.st == ST_SVC);
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ilm,
    input logic       ien,
    input logic       ctx_save_req,
    input logic       ctx_save_done,
    input logic       branch_valid,
    input logic       svc_start,
    input logic       svc_busy,
    input logic       svc_done
);
    AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_save_req && !ctx_save_done |=> ctx_save_req) else $error("save req dropped"); // R4
    AST_ILM_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctx_save_req) |-> (ilm < $past(ilm))) else $error("mask not lowered"); // R4
    AST_ACCEPT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctx_save_req) || svc_start) |-> $past(ien)) else $error("accepted with flag clear"); // R2
    AST_BRANCH_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> $past(ctx_save_req && ctx_save_done)) else $error("branch without save"); // R5
    AST_BRANCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |=> !branch_valid) else $error("branch longer than one cycle"); // R5
    AST_SVC_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_start |-> $stable(ilm)) else $error("service changed mask"); // R7
    AST_SVC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_busy |-> !ctx_save_req) else $error("accept during service"); // R8
    AST_SVC_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        svc_busy && !svc_done |=> !svc_start) else $error("service restarted"); // R8
endmodule

bind irq_accept irq_accept_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ilm           (ilm),
    .ien           (ien),
    .ctx_save_req  (ctx_save_req),
    .ctx_save_done (ctx_save_done),
    .branch_valid  (branch_valid),
    .svc_start     (svc_start),
    .svc_busy      (svc_busy),
    .svc_done      (svc_done)
);

// File: tb/irq_accept_bench.sv
module irq_accept_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_valid = '0;
    logic [N*3-1:0] req_level = '0;
    logic [N*2-1:0] req_kind = '0;
    logic         ps_we = 1'b0;
    logic [2:0]   ps_ilm_in = 3'd7;
    logic         ps_ien_in = 1'b0;
    logic         reti = 1'b0;
    logic         ctx_save_done = 1'b0;
    logic         svc_done = 1'b0;
    logic [2:0]   ilm;
    logic         ien, ctx_save_req, branch_valid, svc_start, svc_busy;
    logic [2:0]   branch_num, svc_num;
    logic [23:0]  branch_vec;
    logic [1:0]   svc_kind;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_accept #(.NUM_IRQ(N)) u_irq_accept (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .req_kind(req_kind), .ps_we(ps_we), .ps_ilm_in(ps_ilm_in), .ps_ien_in(ps_ien_in),
        .reti(reti), .ctx_save_done(ctx_save_done), .svc_done(svc_done),
        .ilm(ilm), .ien(ien), .ctx_save_req(ctx_save_req), .branch_valid(branch_valid),
        .branch_num(branch_num), .branch_vec(branch_vec), .svc_start(svc_start),
        .svc_kind(svc_kind), .svc_num(svc_num), .svc_busy(svc_busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ps(input int m, input bit e);
        ps_we = 1'b1; ps_ilm_in = 3'(m); ps_ien_in = e;
        step();
        ps_we = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1;
        step();
        reti = 1'b0;
    endtask

    task automatic finish_save(input int num, input string tag);
        ctx_save_done = 1'b1;
        step();
        ctx_save_done = 1'b0;
        chk(branch_valid == 1'b1, tag, branch_valid, 1);
        chk(branch_num == 3'(num), tag, branch_num, num);
        chk(branch_vec == 24'hFFFFFC - 24'(4 * num), tag, branch_vec, 24'hFFFFFC - 4 * num);
        step();
        chk(branch_valid == 1'b0, tag, branch_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        step();
        chk(ilm == 3'd7, "R1 mask", ilm, 7);
        chk(ien == 1'b0, "R1 enable", ien, 0);
        chk(!ctx_save_req && !branch_valid && !svc_start && !svc_busy, "R1 outputs", 1, 0);
        rst_n = 1'b1;
        step();

        // R2 R4 R5 R6: sweep of every mask against every level
        for (int m = 0; m < 8; m++) begin
            for (int l = 0; l < 8; l++) begin
                automatic int num = (m + l) % N;
                automatic bit exp_acc = (l < m);
                set_ps(m, 1'b1);
                req_valid[num] = 1'b1;
                req_level[num*3 +: 3] = 3'(l);
                req_kind[num*2 +: 2] = 2'd0;
                step();
                req_valid = '0;
                chk(ctx_save_req == exp_acc, "R2 level vs mask", ctx_save_req, exp_acc);
                if (exp_acc) begin
                    chk(ilm == 3'(l), "R4 mask loaded", ilm, l);
                    step();
                    chk(ctx_save_req == 1'b1, "R4 save held", ctx_save_req, 1);
                    finish_save(num, "R5 branch");
                    do_reti();
                    chk(ilm == 3'(m), "R6 mask restored", ilm, m);
                    chk(ien == 1'b1, "R6 enable restored", ien, 1);
                end
            end
        end

        // R2: flag clear blocks all levels
        set_ps(7, 1'b0);
        for (int l = 0; l < 7; l++) begin
            req_valid[2] = 1'b1;
            req_level[2*3 +: 3] = 3'(l);
            step();
            req_valid = '0;
            chk(ctx_save_req == 1'b0, "R2 flag clear", ctx_save_req, 0);
        end

        // R3: arbitration patterns
        set_ps(7, 1'b1);
        for (int p = 0; p < 24; p++) begin
            automatic int best = -1;
            automatic int bl = 8;
            automatic logic [N-1:0] msk = 8'((p * 37 + 11) | (1 << (p % 8)));
            for (int i = 0; i < N; i++) begin
                automatic int lv = (i * 5 + p * 3) % 8;
                req_level[i*3 +: 3] = 3'(lv);
                req_kind[i*2 +: 2] = 2'(((p + i) % 2) * 3);
                if (msk[i] && lv < 7 && lv < bl) begin
                    bl = lv; best = i;
                end
            end
            req_valid = msk;
            step();
            req_valid = '0;
            chk(ctx_save_req == (best >= 0), "R3 any winner", ctx_save_req, best >= 0);
            if (best >= 0) begin
                chk(ilm == 3'(bl), "R3 winner level", ilm, bl);
                finish_save(best, "R3 winner number");
                do_reti();
            end
        end
        req_kind = '0;

        // R6: write and return block acceptance in that cycle
        req_valid[4] = 1'b1;
        req_level[4*3 +: 3] = 3'd1;
        ps_we = 1'b1; ps_ilm_in = 3'd7; ps_ien_in = 1'b1;
        step();
        ps_we = 1'b0;
        req_valid = '0;
        chk(ctx_save_req == 1'b0, "R6 write blocks accept", ctx_save_req, 0);
        req_valid[4] = 1'b1;
        reti = 1'b1;
        step();
        reti = 1'b0;
        req_valid = '0;
        chk(ctx_save_req == 1'b0, "R6 return blocks accept", ctx_save_req, 0);

        // R7 R8 R9: both service kinds
        for (int k = 1; k <= 2; k++) begin
            set_ps(7, 1'b1);
            req_valid[3] = 1'b1;
            req_level[3*3 +: 3] = 3'd2;
            req_kind[3*2 +: 2] = 2'(k);
            step();
            req_valid = '0;
            chk(svc_start == 1'b1, "R7 start", svc_start, 1);
            chk(svc_kind == 2'(k), "R7 kind", svc_kind, k);
            chk(svc_num == 3'd3, "R7 number", svc_num, 3);
            chk(svc_busy && !ctx_save_req, "R7 no save", ctx_save_req, 0);
            chk(ilm == 3'd7, "R7 mask kept", ilm, 7);
            req_valid[1] = 1'b1;
            req_level[1*3 +: 3] = 3'd0;
            req_kind[1*2 +: 2] = 2'(k);
            for (int c = 0; c < 4; c++) begin
                step();
                chk(!svc_start && !ctx_save_req && svc_busy, "R8 held pending", svc_start, 0);
            end
            req_valid = '0;
            svc_done = 1'b1;
            step();
            svc_done = 1'b0;
            chk(svc_busy == 1'b0, "R7 busy ends", svc_busy, 0);
            step();
            chk(ctx_save_req == 1'b1, "R9 completion raised", ctx_save_req, 1);
            chk(ilm == 3'd2, "R9 completion level", ilm, 2);
            finish_save(3, "R9 completion number");
            do_reti();
            chk(ilm == 3'd7, "R9 mask back", ilm, 7);
        end
        req_kind = '0;

        // R10: nesting
        set_ps(7, 1'b1);
        req_valid[5] = 1'b1;
        req_level[5*3 +: 3] = 3'd4;
        step();
        req_valid = '0;
        finish_save(5, "R10 outer");
        req_valid[6] = 1'b1;
        req_level[6*3 +: 3] = 3'd5;
        step();
        req_valid = '0;
        chk(ctx_save_req == 1'b0, "R10 lower priority held", ctx_save_req, 0);
        req_valid[2] = 1'b1;
        req_level[2*3 +: 3] = 3'd1;
        step();
        req_valid = '0;
        chk(ctx_save_req == 1'b1 && ilm == 3'd1, "R10 inner accepted", ilm, 1);
        finish_save(2, "R10 inner");
        do_reti();
        chk(ilm == 3'd4, "R10 first return", ilm, 4);
        do_reti();
        chk(ilm == 3'd7, "R10 second return", ilm, 7);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule